// File: doc/BRIEF.md
# Flag-Setting Integer ALU

This block is the execute stage arithmetic unit of a small 32-bit core. Each cycle it may accept one operation, named by a 4-bit code, together with two operands: the register operand and the memory operand, the latter being whatever the address and fetch stages have already resolved. One clock edge later it presents the result, a valid strobe, and a writeback enable that tells the register file whether the result is to be stored.

Beside the result, the unit keeps a four-bit status register holding sign, zero, carry and overflow. Add, subtract and compare produce an unsigned carry (or borrow) and a signed overflow as two separate conditions. The bitwise operations derive sign and zero from the result and clear the other two. Inversion and the two pass-through operations leave the status untouched. Compare behaves like subtract for the flags but never asks for writeback.

The status register changes only on an edge where a valid, flag-affecting operation is accepted, so a later conditional-branch unit may read it at any time.

Top module: `alu_flag_unit`

## Requirements
- R1: While rst_n is low at a rising edge, the next outputs are status 0, out_valid 0 and wb_en 0.
- R2: Operation codes are 0 add, 1 subtract, 2 compare, 3 and, 4 or, 5 xor, 6 invert, 7 move, 8 load-address. An operation taken with in_valid high at an edge appears on result, wb_en and status after that edge, with out_valid high.
- R3: Add returns reg_opnd + mem_opnd modulo 2^32. Sign is bit 31 of the result. Zero is set for a zero result. Carry is the unsigned carry out. Overflow is set when the exact signed sum does not fit in 32 bits.
- R4: Subtract returns reg_opnd - mem_opnd modulo 2^32. Sign and zero follow the result. Carry is set when mem_opnd exceeds reg_opnd as unsigned numbers. Overflow is set when the exact signed difference does not fit.
- R5: Compare sets all four status bits exactly as subtract would and drives the difference on result, but with wb_en low.
- R6: And, or and xor return the true bitwise function of the two operands. Sign and zero follow the result, and carry and overflow are cleared.
- R7: Invert returns the bitwise complement of mem_opnd with wb_en high and leaves the status unchanged.
- R8: Move and load-address return mem_opnd unchanged with wb_en high and leave the status unchanged.
- R9: The status port is ordered [3] sign, [2] zero, [1] carry, [0] overflow. It is unchanged after any edge with in_valid low, and out_valid is then low.
- R10: Codes 9 to 15 produce result 0 and wb_en 0, and leave the status unchanged, while out_valid is still raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Operation code (see R2) |
| reg_opnd | input | DATA_W | Register operand (left-hand side) |
| mem_opnd | input | DATA_W | Memory or address operand (right-hand side) |
| out_valid | output | 1 | Result registers hold a new operation |
| result | output | DATA_W | Registered result |
| wb_en | output | 1 | Result is to be written to the destination register |
| status | output | 4 | Sign, zero, carry, overflow (see R9) |

## Verification
The bench builds the unit with the default DATA_W of 32. At that width the sign boundary values 0x7fffffff, 0x80000000 and 0xffffffff can be driven directly. This exercises the cases where carry and overflow disagree, where both are set, and where only one is set, for add, subtract and compare. Back-to-back issue shows that the status register follows only flag-affecting operations. Idle cycles and undefined codes show that the status is held.

// File: rtl/alu_pkg.sv
// Package: shared encodings for the flag-setting ALU.
// Assumes the 4-bit operation code encoding listed in the brief.
package alu_pkg;

    localparam int OP_W   = 4;
    localparam int FLAG_W = 4;

    // Operation codes; values are decoded by neighbouring stages.
    typedef enum logic [OP_W-1:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_CMP = 4'd2,
        OP_AND = 4'd3,
        OP_OR  = 4'd4,
        OP_XOR = 4'd5,
        OP_NOT = 4'd6,
        OP_MOV = 4'd7,
        OP_LEA = 4'd8
    } alu_op_e;

    // Which datapath feeds the result register.
    typedef enum logic [1:0] {
        SEL_ARITH = 2'd0,
        SEL_LOGIC = 2'd1,
        SEL_PASS  = 2'd2,
        SEL_ZERO  = 2'd3
    } res_sel_e;

    // Status bits, packed as [3] sign, [2] zero, [1] carry, [0] overflow.
    typedef struct packed {
        logic sgn;
        logic zer;
        logic cry;
        logic ovf;
    } flags_t;

    // Decoded control for one operation.
    typedef struct packed {
        logic     wb;
        logic     upd;
        logic     sub;
        res_sel_e sel;
    } ctl_t;

endpackage

// File: rtl/alu_decode.sv
// Module: alu_decode
// Turns the raw operation code into datapath controls. Purely combinational.
// Assumes codes above OP_LEA are undefined and must act as a no-op.
module alu_decode
    import alu_pkg::*;
(
    input  logic [OP_W-1:0] op_raw,
    output ctl_t            ctl,
    output alu_op_e         op_typed
);

    // Map each code to writeback, flag update, subtract select and result source.
    always_comb begin
        ctl      = '{wb: 1'b0, upd: 1'b0, sub: 1'b0, sel: SEL_ZERO};
        op_typed = OP_MOV;
        case (op_raw)
            OP_ADD: begin
                ctl      = '{wb: 1'b1, upd: 1'b1, sub: 1'b0, sel: SEL_ARITH};
                op_typed = OP_ADD;
            end
            OP_SUB: begin
                ctl      = '{wb: 1'b1, upd: 1'b1, sub: 1'b1, sel: SEL_ARITH};
                op_typed = OP_SUB;
            end
            OP_CMP: begin
                ctl      = '{wb: 1'b0, upd: 1'b1, sub: 1'b1, sel: SEL_ARITH};
                op_typed = OP_CMP;
            end
            OP_AND: begin
                ctl      = '{wb: 1'b1, upd: 1'b1, sub: 1'b0, sel: SEL_LOGIC};
                op_typed = OP_AND;
            end
            OP_OR: begin
                ctl      = '{wb: 1'b1, upd: 1'b1, sub: 1'b0, sel: SEL_LOGIC};
                op_typed = OP_OR;
            end
            OP_XOR: begin
                ctl      = '{wb: 1'b1, upd: 1'b1, sub: 1'b0, sel: SEL_LOGIC};
                op_typed = OP_XOR;
            end
            OP_NOT: begin
                ctl      = '{wb: 1'b1, upd: 1'b0, sub: 1'b0, sel: SEL_LOGIC};
                op_typed = OP_NOT;
            end
            OP_MOV: begin
                ctl      = '{wb: 1'b1, upd: 1'b0, sub: 1'b0, sel: SEL_PASS};
                op_typed = OP_MOV;
            end
            OP_LEA: begin
                ctl      = '{wb: 1'b1, upd: 1'b0, sub: 1'b0, sel: SEL_PASS};
                op_typed = OP_LEA;
            end
            default: begin
                ctl      = '{wb: 1'b0, upd: 1'b0, sub: 1'b0, sel: SEL_ZERO};
                op_typed = OP_MOV;
            end
        endcase
    end

endmodule

// File: rtl/alu_arith.sv
// Module: alu_arith
// Shared adder/subtractor producing a W-bit result, an unsigned carry
// (borrow when subtracting) and a signed overflow, each derived separately.
// Assumes operands are two's complement when read as signed.
module alu_arith #(
    parameter int W = 32
) (
    input  logic         do_sub,
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output logic [W-1:0] sum,
    output logic         carry,
    output logic         ovf
);

    localparam int EXT_W = W + 1;

    logic [EXT_W-1:0] wide;
    logic             lhs_s;
    logic             rhs_s;
    logic             sum_s;

    // One extra bit holds the carry out or the borrow.
    always_comb begin
        if (do_sub) begin
            wide = {1'b0, lhs} - {1'b0, rhs};
        end else begin
            wide = {1'b0, lhs} + {1'b0, rhs};
        end
    end

    assign sum   = wide[W-1:0];
    assign carry = wide[EXT_W-1];

    assign lhs_s = lhs[W-1];
    assign rhs_s = rhs[W-1];
    assign sum_s = wide[W-1];

    // Signed overflow: operand signs that allow overflow, and a result sign that flips.
    always_comb begin
        if (do_sub) begin
            ovf = (lhs_s != rhs_s) && (sum_s != lhs_s);
        end else begin
            ovf = (lhs_s == rhs_s) && (sum_s != lhs_s);
        end
    end

endmodule

// File: rtl/alu_logic.sv
// Module: alu_logic
// Bitwise unit: and, or, xor of both operands and inversion of the memory operand.
// Assumes the caller ignores its output for non-bitwise codes.
module alu_logic
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e      op,
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output logic [W-1:0] res
);

    // Select the bitwise function named by the code.
    always_comb begin
        case (op)
            OP_AND:  res = lhs & rhs;
            OP_OR:   res = lhs | rhs;
            OP_XOR:  res = lhs ^ rhs;
            OP_NOT:  res = ~rhs;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/alu_flag_unit.sv
// Module: alu_flag_unit (top)
// Registered ALU with a status register. One operation per cycle, and the result
// appears one edge after acceptance. The status register loads only for valid
// flag-affecting operations. Assumes the operands are stable while in_valid is high.
module alu_flag_unit
    import alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        op,
    input  logic [DATA_W-1:0] reg_opnd,
    input  logic [DATA_W-1:0] mem_opnd,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              wb_en,
    output logic [3:0]        status
);

    ctl_t              ctl;
    alu_op_e           op_t;
    logic [DATA_W-1:0] arith_res;
    logic              arith_cry;
    logic              arith_ovf;
    logic [DATA_W-1:0] logic_res;
    logic [DATA_W-1:0] res_c;
    flags_t            flags_c;
    flags_t            flags_q;

    alu_decode u_dec (
        .op_raw   (op),
        .ctl      (ctl),
        .op_typed (op_t)
    );

    alu_arith #(.W(DATA_W)) u_arith (
        .do_sub (ctl.sub),
        .lhs    (reg_opnd),
        .rhs    (mem_opnd),
        .sum    (arith_res),
        .carry  (arith_cry),
        .ovf    (arith_ovf)
    );

    alu_logic #(.W(DATA_W)) u_logic (
        .op  (op_t),
        .lhs (reg_opnd),
        .rhs (mem_opnd),
        .res (logic_res)
    );

    // Result source selection.
    always_comb begin
        case (ctl.sel)
            SEL_ARITH: res_c = arith_res;
            SEL_LOGIC: res_c = logic_res;
            SEL_PASS:  res_c = mem_opnd;
            default:   res_c = '0;
        endcase
    end

    // Next status: sign and zero from the result, carry and overflow only from arithmetic.
    always_comb begin
        flags_c.sgn = res_c[DATA_W-1];
        flags_c.zer = (res_c == '0);
        flags_c.cry = (ctl.sel == SEL_ARITH) ? arith_cry : 1'b0;
        flags_c.ovf = (ctl.sel == SEL_ARITH) ? arith_ovf : 1'b0;
    end

    // Output and status registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            wb_en     <= 1'b0;
            result    <= '0;
            flags_q   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= res_c;
                wb_en  <= ctl.wb;
                if (ctl.upd) begin
                    flags_q <= flags_c;
                end
            end else begin
                wb_en <= 1'b0;
            end
        end
    end

    assign status = flags_q;

endmodule

// File: rtl/alu_flag_unit_chk.sv
// Module: alu_flag_unit_chk
// Property checker for alu_flag_unit, attached by bind below.
// Assumes the status order [3] sign, [2] zero, [1] carry, [0] overflow.
module alu_flag_unit_chk
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [3:0]   op,
    input logic [W-1:0] mem_opnd,
    input logic         out_valid,
    input logic [W-1:0] result,
    input logic         wb_en,
    input logic [3:0]   status
);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (status == 4'd0 && !out_valid && !wb_en)); // R1

    AST_ISSUE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2

    AST_SIGN_ZERO_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op <= 4'(OP_XOR)) |=>
        (status[2] == (result == '0) && status[3] == result[W-1])); // R3

    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 4'(OP_CMP)) |=> !wb_en); // R5

    AST_LOGIC_CV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == 4'(OP_AND) || op == 4'(OP_OR) || op == 4'(OP_XOR)))
        |=> status[1:0] == 2'b00); // R6

    AST_NOT_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 4'(OP_NOT)) |=>
        (result == ~$past(mem_opnd) && $stable(status) && wb_en)); // R7

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == 4'(OP_MOV) || op == 4'(OP_LEA))) |=>
        (result == $past(mem_opnd) && $stable(status) && wb_en)); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(status) && !out_valid)); // R9

    AST_UNDEF_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op > 4'(OP_LEA)) |=>
        (!wb_en && $stable(status) && result == '0)); // R10

endmodule

bind alu_flag_unit alu_flag_unit_chk #(.W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .mem_opnd  (mem_opnd),
    .out_valid (out_valid),
    .result    (result),
    .wb_en     (wb_en),
    .status    (status)
);

// File: tb/sim_alu_flag_unit.sv
// Scoreboard bench: the issue task computes the expected item and queues it,
// and a monitor pops and compares on every valid output.
module sim_alu_flag_unit;

    localparam int W = 32;

    typedef struct packed {
        logic [W-1:0] res;
        logic         wb;
        logic [3:0]   st;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [3:0]   op = 4'd0;
    logic [W-1:0] reg_opnd = '0;
    logic [W-1:0] mem_opnd = '0;
    logic         out_valid;
    logic [W-1:0] result;
    logic         wb_en;
    logic [3:0]   status;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    finished = 1'b0;
    exp_t  exp_q[$];
    string tag_q[$];
    logic [3:0] model_st = 4'd0;

    always #5 clk = ~clk;

    alu_flag_unit #(.DATA_W(W)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op        (op),
        .reg_opnd  (reg_opnd),
        .mem_opnd  (mem_opnd),
        .out_valid (out_valid),
        .result    (result),
        .wb_en     (wb_en),
        .status    (status)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Issue one operation at a falling edge and queue its expected outcome.
    task automatic issue(input string tag, input logic [3:0] code,
                         input logic [W-1:0] a, input logic [W-1:0] b);
        exp_t        e;
        logic [63:0] full;
        longint      sfull;
        logic        s, z, c, o, upd;
        e.res = '0; e.wb = 1'b0; c = 1'b0; o = 1'b0; upd = 1'b0;
        case (code)
            4'd0: begin
                full  = {32'b0, a} + {32'b0, b};
                e.res = full[W-1:0]; e.wb = 1'b1; upd = 1'b1;
                c     = full[W];
                sfull = longint'($signed(a)) + longint'($signed(b));
                o     = (sfull != longint'($signed(e.res)));
            end
            4'd1, 4'd2: begin
                e.res = a - b; e.wb = (code == 4'd1); upd = 1'b1;
                c     = (a < b);
                sfull = longint'($signed(a)) - longint'($signed(b));
                o     = (sfull != longint'($signed(e.res)));
            end
            4'd3: begin e.res = a & b; e.wb = 1'b1; upd = 1'b1; end
            4'd4: begin e.res = a | b; e.wb = 1'b1; upd = 1'b1; end
            4'd5: begin e.res = a ^ b; e.wb = 1'b1; upd = 1'b1; end
            4'd6: begin e.res = ~b; e.wb = 1'b1; end
            4'd7, 4'd8: begin e.res = b; e.wb = 1'b1; end
            default: begin e.res = '0; e.wb = 1'b0; end
        endcase
        s = e.res[W-1];
        z = (e.res == '0);
        if (upd) model_st = {s, z, c, o};
        e.st = model_st;
        @(negedge clk);
        in_valid = 1'b1; op = code; reg_opnd = a; mem_opnd = b;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Drive an idle cycle whose operands would change the status if taken.
    task automatic idle_check();
        @(negedge clk);
        in_valid = 1'b0; op = 4'd0; reg_opnd = 32'hffffffff; mem_opnd = 32'h1;
        @(negedge clk);
        check("R9 idle out_valid", {63'b0, out_valid}, 64'd0);
        check("R9 idle status", {60'b0, status}, {60'b0, model_st});
    endtask

    // Monitor: compare each valid output with the oldest queued expectation.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check("R2 unexpected out_valid", 64'd1, 64'd0);
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({t, " result"}, {32'b0, result}, {32'b0, e.res});
                check({t, " wb_en"}, {63'b0, wb_en}, {63'b0, e.wb});
                check({t, " status"}, {60'b0, status}, {60'b0, e.st});
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset status", {60'b0, status}, 64'd0);
        check("R1 reset out_valid", {63'b0, out_valid}, 64'd0);
        check("R1 reset wb_en", {63'b0, wb_en}, 64'd0);
        rst_n = 1'b1;

        issue("R3 add small", 4'd0, 32'h10, 32'h1);
        issue("R3 add signed ovf", 4'd0, 32'h7fffffff, 32'h1);
        issue("R3 add carry", 4'd0, 32'hffffffff, 32'h1);
        issue("R3 add both", 4'd0, 32'h80000000, 32'h80000000);
        issue("R4 sub small", 4'd1, 32'd10, 32'd1);
        issue("R4 sub borrow", 4'd1, 32'h0, 32'h1);
        issue("R4 sub signed ovf", 4'd1, 32'h80000000, 32'h7fffffff);
        issue("R4 sub both", 4'd1, 32'h0, 32'h80000000);
        issue("R5 cmp less signed", 4'd2, 32'hffffffff, 32'h1);
        issue("R5 cmp less unsigned", 4'd2, 32'h1, 32'hffffffff);
        issue("R5 cmp equal", 4'd2, 32'h0a0b0c0d, 32'h0a0b0c0d);
        issue("R5 cmp ovf", 4'd2, 32'h7fffffff, 32'h80000000);
        issue("R6 and", 4'd3, 32'h0a0b0c0d, 32'h000000ff);
        issue("R6 or", 4'd4, 32'ha0b0c0d0, 32'h0a0b0c0d);
        issue("R6 xor", 4'd5, 32'ha0b0c0d0, 32'haabb0c0d);
        issue("R6 xor zero", 4'd5, 32'h12345678, 32'h12345678);
        issue("R4 set flags", 4'd1, 32'h0, 32'h1);
        issue("R7 not", 4'd6, 32'h0, 32'h0f0f00ff);
        issue("R8 mov", 4'd7, 32'h5, 32'h000000af);
        issue("R8 lea", 4'd8, 32'h5, 32'h00002000);
        issue("R10 undefined 9", 4'd9, 32'h7fffffff, 32'h1);
        issue("R10 undefined 15", 4'd15, 32'hffffffff, 32'hffffffff);
        idle_check();
        issue("R3 add zero", 4'd0, 32'h0, 32'h0);
        idle_check();

        repeat (3) @(negedge clk);
        check("R2 queue drained", 64'(exp_q.size()), 64'd0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule